// File: doc/BRIEF.md
# Priority Interrupt and Trap Controller

This block gathers requests from a small group of non-maskable trap sources and a larger group of maskable interrupt sources. Each request is held in a pending flag. Every cycle the block picks the one pending request with the highest level. It offers that request to the CPU as a vector number and a level, but only when the level is strictly above the CPU's current priority. Trap levels are fixed and always sit above every programmable interrupt level. Interrupt levels are written over a simple write-only register bus.

When the CPU accepts an offer, the block pushes the old CPU priority onto an internal stack and raises the CPU priority to the accepted level. A return pops the stack and restores the earlier priority. A few interrupt sources come from external pins. Each pin passes through a two-flop synchroniser and raises its request on a chosen edge.

Top module: `prio_intr_ctrl`

## Requirements
- R1: After reset, `irqValid` is 0, `cpuPrio` is 0 and `stackErr` is 0. Every interrupt source starts with priority 0 and disabled, and every external pin starts set to rising edge.
- R2: Trap t (0..3) has vector t and fixed level 15-t. Interrupt source i (0..28) has vector 4+i. Sources 0..2 are the external pins (vectors 4..6), and `irqReq[j]` is interrupt source 3+j (vector 7+j).
- R3: A pending trap is always eligible, and any trap outranks any interrupt, whatever the interrupt's setting.
- R4: A register write to address i (0..28) sets source i's priority from data bits [2:0] and its enable from bit 3. An interrupt is eligible only when it is enabled and its priority is nonzero. A request that arrives while the source is ineligible still stays pending.
- R5: `irqValid` is 1 only when an eligible pending request has a level strictly greater than `cpuPrio`. `irqVector` and `irqLevel` then describe the winner.
- R6: When several eligible pending requests share the top level, the lowest vector number wins.
- R7: If `irqValid`, `irqTake` and not `irqReturn` hold at a clock edge, then from the next cycle `cpuPrio` equals the taken level. The previous priority is pushed onto a 16-entry stack, and the taken vector's pending flag is cleared.
- R8: `irqReturn` pops the stack into `cpuPrio`. A return with an empty stack leaves `cpuPrio` unchanged and sets `stackErr`, which stays set until reset. If take and return occur in the same cycle, the return is performed and the take is ignored.
- R9: External pins pass through two synchroniser flops and are edge-triggered. Address 29 bit e selects the edge for pin e: 1 for rising, 0 for falling. The pending flag is set on the third clock edge after the pin changes, and a held level does not re-trigger.
- R10: Writing the value v to address 30 clears the pending flag of vector v.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapReq | input | 4 | Trap request pulses, one bit per trap |
| irqReq | input | 26 | Internal interrupt request pulses |
| extPin | input | 3 | Asynchronous external interrupt pins |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register write address |
| regWrData | input | 8 | Register write data |
| irqTake | input | 1 | CPU accepts the offered request |
| irqReturn | input | 1 | CPU returns from a handler |
| irqValid | output | 1 | A request above the CPU priority is offered |
| irqVector | output | 6 | Vector number of the offered request |
| irqLevel | output | 4 | Level of the offered request |
| cpuPrio | output | 4 | Current CPU priority |
| stackErr | output | 1 | Sticky flag set by a return on an empty stack |

## Verification
The bench nests handlers several levels deep across interrupt and trap levels, then unwinds them. A broken stack would show up as a wrong restored priority, and a missing strict compare would let an equal-level request preempt. It sets up level ties between two sources, which catch a scan that favours the highest index. It also sets up a trap racing a level-7 interrupt, which catches traps not placed above the programmable band.

It exercises a source that was masked while its request arrived, a software clear, a take and a return in the same cycle, and a return on an empty stack. These catch a design that drops pending requests, clears the wrong flag, or corrupts the stack. For the external pins, it checks the exact synchroniser latency, that a held level does not re-trigger, and both edge polarities.

// File: rtl/prio_intr_pkg.sv
package prio_intr_pkg;
  localparam int LVL_W = 4;
  typedef logic [LVL_W-1:0] level_t;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic takeAccept;
    logic popReq;
  } ctlStrobe_t;
endpackage

// File: rtl/prio_intr_dp.sv
module prio_intr_dp
  import prio_intr_pkg::*;
#(
  parameter int NUM_TRAPS = 4,
  parameter int NUM_IRQS  = 29,
  parameter int NUM_EXT   = 3,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int VEC_W     = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_TRAPS-1:0]          trapReq,
  input  logic [NUM_IRQS-NUM_EXT-1:0]   irqReq,
  input  logic [NUM_EXT-1:0]            extPin,
  input  logic                          regWrEn,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [DATA_W-1:0]             regWrData,
  input  level_t                        cpuPrio,
  input  ctlStrobe_t                    strobe,
  output logic                          candValid,
  output logic [VEC_W-1:0]              candVec,
  output level_t                        candLevel
);
  localparam int NUM_SRC  = NUM_TRAPS + NUM_IRQS;
  localparam int POL_ADDR = NUM_IRQS;
  localparam int CLR_ADDR = NUM_IRQS + 1;
  localparam int MAX_LVL  = (1 << LVL_W) - 1;

  // ---------------- external pin path ----------------
  logic [NUM_EXT-1:0] syncA, syncB, syncPrev, edgeSel, extEdge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= extPin;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  generate
    for (genvar e = 0; e < NUM_EXT; e++) begin : g_edge
      assign extEdge[e] = edgeSel[e] ? (syncB[e] & ~syncPrev[e])
                                     : (~syncB[e] & syncPrev[e]);
    end
  endgenerate

  // ---------------- configuration registers ----------------
  logic [2:0]          prioReg [NUM_IRQS];
  logic [NUM_IRQS-1:0] enReg;
  logic                polWr, clrWr;

  assign polWr = regWrEn && (regAddr == ADDR_W'(POL_ADDR));
  assign clrWr = regWrEn && (regAddr == ADDR_W'(CLR_ADDR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeSel <= '1;
    end else if (polWr) begin
      edgeSel <= regWrData[NUM_EXT-1:0];
    end
  end

  generate
    for (genvar i = 0; i < NUM_IRQS; i++) begin : g_cfg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          prioReg[i] <= '0;
          enReg[i]   <= 1'b0;
        end else if (regWrEn && (regAddr == ADDR_W'(i))) begin
          prioReg[i] <= regWrData[2:0];
          enReg[i]   <= regWrData[3];
        end
      end
    end
  endgenerate

  // ---------------- pending flags ----------------
  logic [NUM_SRC-1:0] srcSet, pending, srcElig;
  level_t             srcLevel [NUM_SRC];

  assign srcSet = {irqReq, extEdge, trapReq};

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      if (s < NUM_TRAPS) begin : g_trap
        assign srcLevel[s] = LVL_W'(MAX_LVL - s);
        assign srcElig[s]  = 1'b1;
      end else begin : g_irq
        assign srcLevel[s] = {1'b0, prioReg[s-NUM_TRAPS]};
        assign srcElig[s]  = enReg[s-NUM_TRAPS] && (prioReg[s-NUM_TRAPS] != 3'd0);
      end

      logic clrHit;
      assign clrHit = (strobe.takeAccept && (candVec == VEC_W'(s)))
                   || (clrWr && (regWrData[VEC_W-1:0] == VEC_W'(s)));

      always_ff @(posedge clk) begin
        if (!rstN)           pending[s] <= 1'b0;
        else if (srcSet[s])  pending[s] <= 1'b1;
        else if (clrHit)     pending[s] <= 1'b0;
      end
    end
  endgenerate

  // ---------------- arbitration scan ----------------
  // Strictly-greater update: the lowest index keeps a tie; the seed with
  // cpuPrio enforces preemption only by higher levels.
  always_comb begin
    level_t          bestLvl;
    logic [VEC_W-1:0] bestVec;
    logic            found;
    bestLvl = cpuPrio;
    bestVec = '0;
    found   = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (pending[s] && srcElig[s] && (srcLevel[s] > bestLvl)) begin
        bestLvl = srcLevel[s];
        bestVec = VEC_W'(s);
        found   = 1'b1;
      end
    end
    candValid = found;
    candVec   = bestVec;
    candLevel = bestLvl;
  end

  logic unusedBits;
  assign unusedBits = ^{regWrData[DATA_W-1:VEC_W], strobe.popReq};
endmodule

// File: rtl/prio_intr_ctl.sv
module prio_intr_ctl
  import prio_intr_pkg::*;
#(
  parameter int STACK_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       candValid,
  input  level_t     candLevel,
  input  logic       irqTake,
  input  logic       irqReturn,
  output logic       irqValid,
  output ctlStrobe_t strobe,
  output level_t     cpuPrio,
  output logic       stackErr
);
  localparam int CNT_W = $clog2(STACK_DEPTH + 1);
  localparam int IDX_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;

  level_t           stackMem [STACK_DEPTH];
  logic [CNT_W-1:0] depthCnt;
  logic [CNT_W-1:0] topIdx;
  logic             stackFull, stackEmpty;

  assign stackFull  = (depthCnt == CNT_W'(STACK_DEPTH));
  assign stackEmpty = (depthCnt == '0);
  assign topIdx     = depthCnt - CNT_W'(1);

  assign irqValid          = candValid && !stackFull;
  assign strobe.popReq     = irqReturn;
  assign strobe.takeAccept = irqTake && irqValid && !irqReturn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depthCnt <= '0;
      cpuPrio  <= '0;
      stackErr <= 1'b0;
      for (int k = 0; k < STACK_DEPTH; k++) stackMem[k] <= '0;
    end else if (strobe.popReq) begin
      if (stackEmpty) begin
        stackErr <= 1'b1;
      end else begin
        cpuPrio  <= stackMem[topIdx[IDX_W-1:0]];
        depthCnt <= topIdx;
      end
    end else if (strobe.takeAccept) begin
      stackMem[depthCnt[IDX_W-1:0]] <= cpuPrio;
      depthCnt <= depthCnt + CNT_W'(1);
      cpuPrio  <= candLevel;
    end
  end
endmodule

// File: rtl/prio_intr_ctrl.sv
module prio_intr_ctrl
  import prio_intr_pkg::*;
#(
  parameter int NUM_TRAPS   = 4,
  parameter int NUM_IRQS    = 29,
  parameter int NUM_EXT     = 3,
  parameter int STACK_DEPTH = 16,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = $clog2(NUM_IRQS + 2),
  parameter int VEC_W       = $clog2(NUM_TRAPS + NUM_IRQS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_TRAPS-1:0]        trapReq,
  input  logic [NUM_IRQS-NUM_EXT-1:0] irqReq,
  input  logic [NUM_EXT-1:0]          extPin,
  input  logic                        regWrEn,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [DATA_W-1:0]           regWrData,
  input  logic                        irqTake,
  input  logic                        irqReturn,
  output logic                        irqValid,
  output logic [VEC_W-1:0]            irqVector,
  output logic [LVL_W-1:0]            irqLevel,
  output logic [LVL_W-1:0]            cpuPrio,
  output logic                        stackErr
);
  ctlStrobe_t strobe;
  logic       candValid;
  level_t     candLevel;

  prio_intr_dp #(
    .NUM_TRAPS(NUM_TRAPS), .NUM_IRQS(NUM_IRQS), .NUM_EXT(NUM_EXT),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .irqReq(irqReq), .extPin(extPin),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .cpuPrio(cpuPrio), .strobe(strobe),
    .candValid(candValid), .candVec(irqVector), .candLevel(candLevel)
  );

  prio_intr_ctl #(.STACK_DEPTH(STACK_DEPTH)) ctl_i (
    .clk(clk), .rstN(rstN), .candValid(candValid), .candLevel(candLevel),
    .irqTake(irqTake), .irqReturn(irqReturn), .irqValid(irqValid),
    .strobe(strobe), .cpuPrio(cpuPrio), .stackErr(stackErr)
  );

  assign irqLevel = candLevel;
endmodule

// File: rtl/prio_intr_ctrl_chk.sv
module prio_intr_ctrl_chk #(
  parameter int NUM_TRAPS = 4,
  parameter int VEC_W     = 6,
  parameter int LVL_W     = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             irqValid,
  input logic [VEC_W-1:0] irqVector,
  input logic [LVL_W-1:0] irqLevel,
  input logic             irqTake,
  input logic             irqReturn,
  input logic [LVL_W-1:0] cpuPrio,
  input logic             stackErr
);
  // R5: an offer always beats the CPU priority
  a_r5_offer_above_cpu: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (irqLevel > cpuPrio));

  // R3: levels 8 and above belong to traps only
  a_r3_trap_band: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> ((irqLevel >= LVL_W'(8)) == (irqVector < VEC_W'(NUM_TRAPS))));

  // R7: a take raises the CPU priority to the taken level
  a_r7_take_raises: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && irqTake && !irqReturn) |=> (cpuPrio == $past(irqLevel)));

  // R8: without an accepted take the CPU priority never rises
  a_r8_no_rise: assert property (@(posedge clk) disable iff (!rstN)
    !(irqValid && irqTake && !irqReturn) |=> (cpuPrio <= $past(cpuPrio)));

  // R8: the underflow flag is sticky
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    stackErr |=> stackErr);
endmodule

bind prio_intr_ctrl prio_intr_ctrl_chk #(
  .NUM_TRAPS(NUM_TRAPS), .VEC_W(VEC_W), .LVL_W(prio_intr_pkg::LVL_W)
) chk_i (
  .clk(clk), .rstN(rstN), .irqValid(irqValid), .irqVector(irqVector),
  .irqLevel(irqLevel), .irqTake(irqTake), .irqReturn(irqReturn),
  .cpuPrio(cpuPrio), .stackErr(stackErr)
);

// File: tb/prio_intr_ctrl_tb_top.sv
module prio_intr_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  trapReq = '0;
  logic [25:0] irqReq = '0;
  logic [2:0]  extPin = '0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic        irqTake = 1'b0;
  logic        irqReturn = 1'b0;
  logic        irqValid;
  logic [5:0]  irqVector;
  logic [3:0]  irqLevel;
  logic [3:0]  cpuPrio;
  logic        stackErr;

  int nChecks = 0;
  int nFail = 0;

  typedef struct { int vec; int lvl; string tag; } expItem_t;
  expItem_t expQ[$];

  always #2 clk = ~clk;

  prio_intr_ctrl dut_i (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .irqReq(irqReq), .extPin(extPin),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .irqTake(irqTake), .irqReturn(irqReturn), .irqValid(irqValid),
    .irqVector(irqVector), .irqLevel(irqLevel), .cpuPrio(cpuPrio), .stackErr(stackErr)
  );

  task automatic chkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic ticks(input int n); for (int k = 0; k < n; k++) tick(); endtask

  task automatic regWrite(input int addr, input int data);
    regWrEn = 1'b1; regAddr = 5'(addr); regWrData = 8'(data);
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic pulseIrq(input int j);
    irqReq[j] = 1'b1; tick(); irqReq[j] = 1'b0;
  endtask

  task automatic pulseTrap(input int t);
    trapReq[t] = 1'b1; tick(); trapReq[t] = 1'b0;
  endtask

  // driver: queue the expected offer, then raise the take for one cycle
  task automatic takeExpect(input int vec, input int lvl, input string tag);
    expItem_t it;
    it.vec = vec; it.lvl = lvl; it.tag = tag;
    expQ.push_back(it);
    irqTake = 1'b1; tick(); irqTake = 1'b0;
    chkEq({tag, " R7 cpuPrio after take"}, cpuPrio, lvl);
  endtask

  task automatic doReturn(input int expPrio, input string tag);
    irqReturn = 1'b1; tick(); irqReturn = 1'b0;
    chkEq({tag, " R8 cpuPrio after return"}, cpuPrio, expPrio);
  endtask

  task automatic chkOffer(input string tag, input int v, input int vec, input int lvl);
    chkEq({tag, " valid"}, irqValid, v);
    if (v == 1) begin
      chkEq({tag, " vector"}, irqVector, vec);
      chkEq({tag, " level"}, irqLevel, lvl);
    end
  endtask

  // monitor: compare each take against the scoreboard
  always @(negedge clk) begin
    if (rstN && irqTake && !irqReturn) begin
      expItem_t e;
      if (expQ.size() == 0) begin
        chkEq("R7 unexpected take", 1, 0);
      end else begin
        e = expQ.pop_front();
        chkEq({e.tag, " scoreboard valid"}, irqValid, 1);
        chkEq({e.tag, " scoreboard vector"}, irqVector, e.vec);
        chkEq({e.tag, " scoreboard level"}, irqLevel, e.lvl);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    ticks(3);
    rstN = 1'b1;
    tick();
    // R1 reset state
    chkEq("R1 valid after reset", irqValid, 0);
    chkEq("R1 cpuPrio after reset", cpuPrio, 0);
    chkEq("R1 stackErr after reset", stackErr, 0);

    // R4 default-disabled source stays pending but is not offered
    pulseIrq(0);                     // vector 7
    tick();
    chkOffer("R1 R4 default disabled", 0, 0, 0);
    regWrite(3, 8'h05);              // prio 5, enable 0
    chkOffer("R4 enable bit required", 0, 0, 0);
    regWrite(3, 8'h0D);              // prio 5, enabled
    chkOffer("R4 R2 pending kept", 1, 7, 5);

    // R10 software clear; R4 priority 0 never eligible
    regWrite(4, 8'h08);              // vector 8: enabled, prio 0
    pulseIrq(1);
    regWrite(30, 7);
    chkOffer("R10 R4 clear and prio0", 0, 0, 0);

    // R6 tie at level 5: lowest vector wins
    regWrite(4, 8'h0D);
    chkOffer("R4 vector 8 now eligible", 1, 8, 5);
    pulseIrq(0);
    chkOffer("R6 tie lowest vector", 1, 7, 5);
    takeExpect(7, 5, "R6");
    chkOffer("R5 equal level not offered", 0, 0, 0);
    doReturn(0, "R8");
    chkOffer("R5 offer after return", 1, 8, 5);
    takeExpect(8, 5, "R7");
    doReturn(0, "R8");

    // nesting through interrupt and trap levels
    regWrite(5, 8'h0A);              // vector 9 prio 2
    regWrite(6, 8'h0E);              // vector 10 prio 6
    pulseIrq(2);
    takeExpect(9, 2, "R7 nest1");
    pulseIrq(3);
    chkOffer("R5 higher preempts", 1, 10, 6);
    takeExpect(10, 6, "R7 nest2");
    trapReq[3] = 1'b1; irqReq[2] = 1'b1; tick(); trapReq[3] = 1'b0; irqReq[2] = 1'b0;
    chkOffer("R3 R2 trap 3 level", 1, 3, 12);
    takeExpect(3, 12, "R3 nest3");
    pulseTrap(0);
    chkOffer("R2 trap 0 level", 1, 0, 15);
    takeExpect(0, 15, "R3 nest4");
    doReturn(12, "R8 unwind");
    doReturn(6, "R8 unwind");
    doReturn(2, "R8 unwind");
    chkOffer("R5 equal after unwind", 0, 0, 0);
    doReturn(0, "R8 unwind");
    chkOffer("R5 pending reoffered", 1, 9, 2);
    takeExpect(9, 2, "R7");
    doReturn(0, "R8");

    // R3 trap beats a level-7 interrupt raised in the same cycle
    regWrite(6, 8'h0F);
    trapReq[2] = 1'b1; irqReq[3] = 1'b1; tick(); trapReq[2] = 1'b0; irqReq[3] = 1'b0;
    chkOffer("R3 trap over level 7", 1, 2, 13);
    takeExpect(2, 13, "R3");
    chkOffer("R5 level 7 masked by trap", 0, 0, 0);
    doReturn(0, "R8");
    chkOffer("R3 interrupt after trap", 1, 10, 7);
    takeExpect(10, 7, "R7");
    doReturn(0, "R8");

    // R8 empty-stack return
    doReturn(0, "R8 underflow");
    chkEq("R8 stackErr set", stackErr, 1);
    tick();
    chkEq("R8 stackErr sticky", stackErr, 1);

    // R8 take and return in the same cycle
    pulseIrq(2);
    takeExpect(9, 2, "R7");
    pulseIrq(3);
    irqTake = 1'b1; irqReturn = 1'b1; tick(); irqTake = 1'b0; irqReturn = 1'b0;
    chkEq("R8 return wins cpuPrio", cpuPrio, 0);
    chkOffer("R8 take ignored keeps pending", 1, 10, 7);
    takeExpect(10, 7, "R8");
    doReturn(0, "R8");

    // R9 external pins
    regWrite(1, 8'h0C);              // pin 1 -> vector 5, prio 4
    extPin[1] = 1'b1;
    ticks(2);
    chkOffer("R9 not before sync latency", 0, 0, 0);
    tick();
    chkOffer("R9 rising edge after 3 edges", 1, 5, 4);
    takeExpect(5, 4, "R9");
    ticks(6);
    chkOffer("R9 held level no retrigger", 0, 0, 0);
    extPin[1] = 1'b0; ticks(5);
    chkOffer("R9 falling ignored when rising set", 0, 0, 0);
    doReturn(0, "R9");

    regWrite(0, 8'h0B);              // pin 0 -> vector 4, prio 3
    regWrite(29, 8'h06);             // pin 0 falling, others rising
    extPin[0] = 1'b1; ticks(5);
    chkOffer("R9 rising ignored when falling set", 0, 0, 0);
    extPin[0] = 1'b0; ticks(5);
    chkOffer("R9 falling edge", 1, 4, 3);
    takeExpect(4, 3, "R9");
    doReturn(0, "R9");

    ticks(2);
    chkEq("R7 scoreboard drained", expQ.size(), 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule